// File: doc/BRIEF.md
# PHY Configuration Register Sequencer

This block brings up a video-transmitter PHY by writing its byte-wide configuration registers in a fixed order and then waiting for the PHY's PLL to report lock. A start pulse hands it seven PLL divider bytes and three lock-detector register images. The block captures them and issues fifty register writes over a simple write-valid/ready bus. First it sets a hold bit in the mode register. Then it loads a table of constant register values, the divider bytes, a clock-select register that reuses one nibble of a divider byte, and the lock-detector images. Last it writes the release bit to the mode register.

After the release write, the block reads the status register at fixed intervals. Read data returns on the cycle after the request. The block stops when the lock bit is seen or when the poll budget is used up. The interval and the budget come from the clock frequency, the poll period and the overall timeout. At the end the block pulses done and holds one of two outcome flags, lock-ok or timeout, until the next start.

Top module: `phy_cfg_seq`

## Requirements
- R1: While reset (rst_ni low, asynchronous) is active and after its release, bus_wvalid_o, bus_rreq_o, done_o, lock_ok_o and timeout_o are all 0. A reset in the middle of a sequence returns the block to idle with all of these at 0.
- R2: A start_i pulse while idle captures pll_div_i and lock_det_i and begins the sequence. The first write goes to register 33 (byte address = register index times 4, here 132) with data 0x02, which is the hold bit 1 alone.
- R3: The next 37 writes cover registers 0, 8 to 11, 15 to 20 and 22 to 47 in ascending order. Their values are 8=0x4F, 9=0x30, 10=0x33, 11=0x65, 15=0x80, 16=0x6C, 17=0xF2, 18=0x67, 20=0x10, 22=0x30, 23=0x32, 24=0x60, 25=0x8F, 28=0x08, 33=0x80, 41=0xE0, 42=0x83, 43=0x0F, 44=0x3E and 45=0xF8. Every other register in the list gets 0x00.
- R4: The next seven writes go to registers 1 to 7 in ascending order. Register 1+i receives byte i of pll_div_i, which is bits 8i+7:8i.
- R5: The next write goes to register 21. Its data has bit 7 set, bits 6:4 clear, and bits 7:4 of pll_div_i byte 2 in bits 3:0.
- R6: The next three writes put lock_det_i bytes 0, 1 and 2 into registers 12, 13 and 14. The last write puts 0x82 (release bit 7 plus hold bit 1) into register 33, for 50 writes in all. The first status read follows on the very next cycle.
- R7: A write is offered with bus_wvalid_o high. Address and data stay stable until a cycle with bus_wready_i high accepts it. The next write, or any read, starts only after that acceptance.
- R8: A status poll raises bus_rreq_o for one cycle with address 136 (register 34). It takes bus_rdata_i on the following cycle. Only bit 6 of that byte decides lock; the other bits have no effect.
- R9: After a poll without lock, the block waits POLL_CYC = CLK_MHZ*POLL_US idle cycles before the next request, so requests are POLL_CYC+2 cycles apart.
- R10: The poll budget is MAX_POLLS = TIMEOUT_US/POLL_US reads. If none of them shows lock, timeout_o is set and lock_ok_o stays 0. Lock seen on the last permitted read gives lock_ok_o=1 and no timeout.
- R11: done_o is high for exactly one cycle at the end of each sequence, whatever the outcome. lock_ok_o and timeout_o hold their result until the next accepted start, which clears both.
- R12: A start_i pulse during an active sequence is ignored. Changes on pll_div_i and lock_det_i after the start is accepted do not change any write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a configuration sequence (idle only) |
| pll_div_i | input | 56 | Seven PLL divider bytes, byte i for register 1+i |
| lock_det_i | input | 24 | Lock-detector images for registers 12, 13, 14 |
| bus_addr_o | output | 8 | Register byte address for write or read |
| bus_wdata_o | output | 8 | Write data |
| bus_wvalid_o | output | 1 | Write offered |
| bus_wready_i | input | 1 | Write accepted this cycle |
| bus_rreq_o | output | 1 | Status read request, one cycle |
| bus_rdata_i | input | 8 | Read data, valid the cycle after the request |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| lock_ok_o | output | 1 | PLL lock observed in the last sequence |
| timeout_o | output | 1 | Poll budget exhausted without lock |

## Verification
The properties assume the bus returns status data exactly one cycle after each read request. They also assume the write acceptor may hold ready low for any number of cycles but never retracts an acceptance it has already given. Start pulses are assumed to matter only while idle. The stimulus keeps to these limits: it decides ready and read data on the falling edge, so every value is stable at the next rising edge. It returns read data only in the cycle after a request, and it keeps each start pulse to one cycle. Lock is injected on a chosen poll number. Filler bits are set in unlocked status bytes so that any decode of a bit other than the lock bit shows up in the outcome.

// File: rtl/phy_cfg_pkg.sv
package phy_cfg_pkg;

    localparam int REG_IDX_W  = 6;
    localparam int ADDR_W     = REG_IDX_W + 2;
    localparam int DATA_W     = 8;
    localparam int PLL_BYTES  = 7;
    localparam int LD_BYTES   = 3;
    localparam int COMMON_CNT = 37;
    localparam int NUM_WRITES = 1 + COMMON_CNT + PLL_BYTES + 1 + LD_BYTES + 1;
    localparam int STEP_W     = $clog2(NUM_WRITES);

    localparam logic [REG_IDX_W-1:0] IDX_MODE   = 6'd33;
    localparam logic [REG_IDX_W-1:0] IDX_STATUS = 6'd34;
    localparam logic [REG_IDX_W-1:0] IDX_CLKSEL = 6'd21;
    localparam logic [REG_IDX_W-1:0] IDX_PLL0   = 6'd1;
    localparam logic [REG_IDX_W-1:0] IDX_LD0    = 6'd12;

    localparam int HOLD_BIT    = 1;
    localparam int RELEASE_BIT = 7;
    localparam int LOCK_BIT    = 6;
    localparam int INV_BIT     = 7;
    localparam int S_SRC_BYTE  = 2;

    localparam logic [DATA_W-1:0] MODE_HOLD    = DATA_W'(1 << HOLD_BIT);
    localparam logic [DATA_W-1:0] MODE_RELEASE = DATA_W'((1 << HOLD_BIT) | (1 << RELEASE_BIT));

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_READ,
        ST_RDATA,
        ST_WAIT,
        ST_FIN
    } seq_state_e;

    // Position k of the constant table maps to a register index: 0, 8..11, 15..20, 22..47.
    function automatic logic [REG_IDX_W-1:0] common_index(input logic [REG_IDX_W-1:0] k);
        if (k == '0)
            return '0;
        else if (k <= 6'd4)
            return k + 6'd7;
        else if (k <= 6'd10)
            return k + 6'd10;
        else
            return k + 6'd11;
    endfunction

    function automatic logic [DATA_W-1:0] common_value(input logic [REG_IDX_W-1:0] idx);
        logic [DATA_W-1:0] v;
        case (idx)
            6'd8:    v = 8'h4F;
            6'd9:    v = 8'h30;
            6'd10:   v = 8'h33;
            6'd11:   v = 8'h65;
            6'd15:   v = 8'h80;
            6'd16:   v = 8'h6C;
            6'd17:   v = 8'hF2;
            6'd18:   v = 8'h67;
            6'd20:   v = 8'h10;
            6'd22:   v = 8'h30;
            6'd23:   v = 8'h32;
            6'd24:   v = 8'h60;
            6'd25:   v = 8'h8F;
            6'd28:   v = 8'h08;
            6'd33:   v = 8'h80;
            6'd41:   v = 8'hE0;
            6'd42:   v = 8'h83;
            6'd43:   v = 8'h0F;
            6'd44:   v = 8'h3E;
            6'd45:   v = 8'hF8;
            default: v = 8'h00;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/phy_cfg_step_rom.sv
module phy_cfg_step_rom
    import phy_cfg_pkg::*;
(
    input  logic [STEP_W-1:0]           step_i,
    input  logic [PLL_BYTES*DATA_W-1:0] pll_i,
    input  logic [LD_BYTES*DATA_W-1:0]  ld_i,
    output logic [REG_IDX_W-1:0]        idx_o,
    output logic [DATA_W-1:0]           data_o
);

    localparam logic [STEP_W-1:0] S_COMMON0 = STEP_W'(1);
    localparam logic [STEP_W-1:0] S_PLL0    = STEP_W'(1 + COMMON_CNT);
    localparam logic [STEP_W-1:0] S_CLKSEL  = STEP_W'(1 + COMMON_CNT + PLL_BYTES);
    localparam logic [STEP_W-1:0] S_LD0     = STEP_W'(2 + COMMON_CNT + PLL_BYTES);
    localparam logic [STEP_W-1:0] S_RELEASE = STEP_W'(NUM_WRITES - 1);

    logic [DATA_W-1:0] pll_b [PLL_BYTES];
    logic [DATA_W-1:0] ld_b  [LD_BYTES];

    for (genvar g = 0; g < PLL_BYTES; g++) begin : g_pll
        assign pll_b[g] = pll_i[DATA_W*g +: DATA_W];
    end
    for (genvar g = 0; g < LD_BYTES; g++) begin : g_ld
        assign ld_b[g] = ld_i[DATA_W*g +: DATA_W];
    end

    logic [REG_IDX_W-1:0] tbl_pos;
    logic [2:0]           pll_sel;
    logic [1:0]           ld_sel;

    always_comb begin
        tbl_pos = REG_IDX_W'(step_i - S_COMMON0);
        pll_sel = 3'(step_i - S_PLL0);
        ld_sel  = 2'(step_i - S_LD0);
        idx_o   = IDX_MODE;
        data_o  = MODE_HOLD;
        if (step_i == '0) begin
            idx_o  = IDX_MODE;
            data_o = MODE_HOLD;
        end else if (step_i < S_PLL0) begin
            idx_o  = common_index(tbl_pos);
            data_o = common_value(common_index(tbl_pos));
        end else if (step_i < S_CLKSEL) begin
            idx_o  = IDX_PLL0 + {3'b000, pll_sel};
            data_o = pll_b[pll_sel];
        end else if (step_i == S_CLKSEL) begin
            idx_o  = IDX_CLKSEL;
            data_o = '0;
            data_o[INV_BIT] = 1'b1;
            data_o[3:0]     = pll_b[S_SRC_BYTE][7:4];
        end else if (step_i < S_RELEASE) begin
            idx_o  = IDX_LD0 + {4'b0000, ld_sel};
            data_o = ld_b[ld_sel];
        end else begin
            idx_o  = IDX_MODE;
            data_o = MODE_RELEASE;
        end
    end

endmodule

// File: rtl/phy_cfg_interval_timer.sv
module phy_cfg_interval_timer #(
    parameter int CYCLES = 5000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    output logic expire_o
);

    localparam int CNT_W = (CYCLES < 2) ? 1 : $clog2(CYCLES);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        expire_o = run_i && (cnt_q == LAST);
        if (!run_i || expire_o)
            cnt_d = '0;
        else
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

endmodule

// File: rtl/phy_cfg_seq.sv
module phy_cfg_seq
    import phy_cfg_pkg::*;
#(
    parameter int CLK_MHZ    = 100,
    parameter int POLL_US    = 50,
    parameter int TIMEOUT_US = 20000
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        start_i,
    input  logic [55:0] pll_div_i,
    input  logic [23:0] lock_det_i,
    output logic [7:0]  bus_addr_o,
    output logic [7:0]  bus_wdata_o,
    output logic        bus_wvalid_o,
    input  logic        bus_wready_i,
    output logic        bus_rreq_o,
    input  logic [7:0]  bus_rdata_i,
    output logic        done_o,
    output logic        lock_ok_o,
    output logic        timeout_o
);

    localparam int POLL_CYC  = CLK_MHZ * POLL_US;
    localparam int MAX_POLLS = (TIMEOUT_US / POLL_US < 1) ? 1 : TIMEOUT_US / POLL_US;
    localparam int POLL_W    = $clog2(MAX_POLLS + 1);
    localparam logic [POLL_W-1:0] LAST_POLL = POLL_W'(MAX_POLLS - 1);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_WRITES - 1);
    localparam logic [ADDR_W-1:0] STATUS_ADDR = {IDX_STATUS, 2'b00};

    typedef struct packed {
        seq_state_e                  state;
        logic [STEP_W-1:0]           step;
        logic [POLL_W-1:0]           polls;
        logic [PLL_BYTES*DATA_W-1:0] pll;
        logic [LD_BYTES*DATA_W-1:0]  ld;
        logic                        lock;
        logic                        tout;
    } seq_regs_t;

    seq_regs_t d, q;

    logic [REG_IDX_W-1:0] rom_idx;
    logic [DATA_W-1:0]    rom_data;
    logic                 tick;
    logic                 rdata_unused;

    assign rdata_unused = ^{bus_rdata_i[7], bus_rdata_i[5:0]};

    phy_cfg_step_rom u_rom (
        .step_i (q.step),
        .pll_i  (q.pll),
        .ld_i   (q.ld),
        .idx_o  (rom_idx),
        .data_o (rom_data)
    );

    phy_cfg_interval_timer #(
        .CYCLES (POLL_CYC)
    ) u_timer (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .run_i    (q.state == ST_WAIT),
        .expire_o (tick)
    );

    always_comb begin
        d = q;
        unique case (q.state)
            ST_IDLE: begin
                if (start_i) begin
                    d.state = ST_WRITE;
                    d.step  = '0;
                    d.polls = '0;
                    d.pll   = pll_div_i;
                    d.ld    = lock_det_i;
                    d.lock  = 1'b0;
                    d.tout  = 1'b0;
                end
            end
            ST_WRITE: begin
                if (bus_wready_i) begin
                    if (q.step == LAST_STEP)
                        d.state = ST_READ;
                    else
                        d.step = q.step + 1'b1;
                end
            end
            ST_READ: begin
                d.state = ST_RDATA;
            end
            ST_RDATA: begin
                if (bus_rdata_i[LOCK_BIT]) begin
                    d.lock  = 1'b1;
                    d.state = ST_FIN;
                end else if (q.polls == LAST_POLL) begin
                    d.tout  = 1'b1;
                    d.state = ST_FIN;
                end else begin
                    d.polls = q.polls + 1'b1;
                    d.state = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (tick)
                    d.state = ST_READ;
            end
            ST_FIN: begin
                d.state = ST_IDLE;
            end
            default: begin
                d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q.state <= ST_IDLE;
            q.step  <= '0;
            q.polls <= '0;
            q.pll   <= '0;
            q.ld    <= '0;
            q.lock  <= 1'b0;
            q.tout  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign bus_wvalid_o = (q.state == ST_WRITE);
    assign bus_rreq_o   = (q.state == ST_READ);
    assign bus_addr_o   = (q.state == ST_READ) ? STATUS_ADDR : {rom_idx, 2'b00};
    assign bus_wdata_o  = rom_data;
    assign done_o       = (q.state == ST_FIN);
    assign lock_ok_o    = q.lock;
    assign timeout_o    = q.tout;

endmodule

// File: rtl/phy_cfg_seq_chk.sv
module phy_cfg_seq_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       wvalid,
    input logic       wready,
    input logic       rreq,
    input logic [7:0] addr,
    input logic [7:0] wdata,
    input logic       done,
    input logic       lock_ok,
    input logic       timeout
);

    assert_wr_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wvalid && !wready) |=> (wvalid && $stable(addr) && $stable(wdata)));

    assert_rreq_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rreq |=> !rreq);

    assert_status_addr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rreq |-> (addr == 8'd136));

    assert_first_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(wvalid) |-> (addr == 8'd132 && wdata == 8'h02 && !lock_ok && !timeout));

    assert_release_then_poll_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(wvalid) |-> (rreq && $past(addr) == 8'd132 && $past(wdata) == 8'h82));

    assert_done_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done |=> !done);

    assert_done_outcome_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done |-> (lock_ok ^ timeout));

endmodule

bind phy_cfg_seq phy_cfg_seq_chk u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wvalid  (bus_wvalid_o),
    .wready  (bus_wready_i),
    .rreq    (bus_rreq_o),
    .addr    (bus_addr_o),
    .wdata   (bus_wdata_o),
    .done    (done_o),
    .lock_ok (lock_ok_o),
    .timeout (timeout_o)
);

// File: tb/phy_cfg_seq_test.sv
`timescale 1ns/1ps
module phy_cfg_seq_test;

    localparam int POLL_CYC  = 3;
    localparam int MAX_POLLS = 4;
    localparam int LOGN      = 1024;

    typedef struct packed {
        logic [55:0] pll;
        logic [23:0] ld;
        logic        stall;
        logic [7:0]  lock_after;
        logic [7:0]  exp_reads;
        logic        exp_lock;
        logic        exp_tout;
    } scen_t;

    localparam int NSCEN = 5;
    localparam scen_t SCEN [NSCEN] = '{
        '{56'h40_84_90_0d_52_5c_d1, 24'h45_12_30, 1'b0, 8'd1,   8'd1, 1'b1, 1'b0},
        '{56'h45_88_01_82_34_66_d1, 24'h43_0f_21, 1'b1, 8'd3,   8'd3, 1'b1, 1'b0},
        '{56'h40_80_08_95_74_62_d1, 24'h41_ff_10, 1'b0, 8'd255, 8'd4, 1'b0, 1'b1},
        '{56'h55_96_08_8b_18_43_d1, 24'h44_a5_00, 1'b1, 8'd4,   8'd4, 1'b1, 1'b0},
        '{56'h00_00_00_00_a5_00_00, 24'h00_00_00, 1'b0, 8'd2,   8'd2, 1'b1, 1'b0}
    };

    // {register index, value} of the constant table, in write order
    localparam logic [15:0] COMMON_EXP [37] = '{
        {8'd0, 8'h00},  {8'd8, 8'h4F},  {8'd9, 8'h30},  {8'd10, 8'h33}, {8'd11, 8'h65},
        {8'd15, 8'h80}, {8'd16, 8'h6C}, {8'd17, 8'hF2}, {8'd18, 8'h67}, {8'd19, 8'h00},
        {8'd20, 8'h10}, {8'd22, 8'h30}, {8'd23, 8'h32}, {8'd24, 8'h60}, {8'd25, 8'h8F},
        {8'd26, 8'h00}, {8'd27, 8'h00}, {8'd28, 8'h08}, {8'd29, 8'h00}, {8'd30, 8'h00},
        {8'd31, 8'h00}, {8'd32, 8'h00}, {8'd33, 8'h80}, {8'd34, 8'h00}, {8'd35, 8'h00},
        {8'd36, 8'h00}, {8'd37, 8'h00}, {8'd38, 8'h00}, {8'd39, 8'h00}, {8'd40, 8'h00},
        {8'd41, 8'hE0}, {8'd42, 8'h83}, {8'd43, 8'h0F}, {8'd44, 8'h3E}, {8'd45, 8'hF8},
        {8'd46, 8'h00}, {8'd47, 8'h00}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [55:0] pll_div;
    logic [23:0] lock_det;
    logic [7:0]  addr, wdata, rdata;
    logic        wvalid, wready, rreq, done, lock_ok, timeout;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // responder-owned state
    int cyc = 0;
    int wr_cnt = 0, rd_cnt = 0, done_cnt = 0, rd_bad = 0, ovl_cnt = 0;
    logic [7:0] log_addr [LOGN];
    logic [7:0] log_data [LOGN];
    int rd_cyc [LOGN];
    bit pend_rd = 0;

    // main-owned controls for the responder
    bit stall_mode;
    int lock_at;

    always #10 clk = ~clk;

    phy_cfg_seq #(
        .CLK_MHZ    (1),
        .POLL_US    (3),
        .TIMEOUT_US (12)
    ) uut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .start_i      (start),
        .pll_div_i    (pll_div),
        .lock_det_i   (lock_det),
        .bus_addr_o   (addr),
        .bus_wdata_o  (wdata),
        .bus_wvalid_o (wvalid),
        .bus_wready_i (wready),
        .bus_rreq_o   (rreq),
        .bus_rdata_i  (rdata),
        .done_o       (done),
        .lock_ok_o    (lock_ok),
        .timeout_o    (timeout)
    );

    // Bus responder: decides ready and read data on the falling edge.
    initial begin
        wready = 1'b0;
        rdata  = 8'h00;
        forever begin
            @(negedge clk);
            cyc++;
            wready = stall_mode ? (cyc % 3 == 0) : 1'b1;
            if (wvalid && rreq) ovl_cnt++;
            if (wvalid && wready) begin
                log_addr[wr_cnt % LOGN] = addr;
                log_data[wr_cnt % LOGN] = wdata;
                wr_cnt++;
            end
            // unlocked status carries all other bits set (R8)
            rdata = pend_rd ? ((rd_cnt >= lock_at) ? 8'h40 : 8'hBF) : 8'h00;
            pend_rd = rreq;
            if (rreq) begin
                rd_cyc[rd_cnt % LOGN] = cyc;
                if (addr != 8'd136) rd_bad++;
                rd_cnt++;
            end
            if (done) done_cnt++;
        end
    end

    task automatic check_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_write(input int k, input logic [55:0] pll, input logic [23:0] ld);
        logic [15:0] e;
        if (k == 0)
            return {8'd132, 8'h02};
        else if (k < 38) begin
            e = COMMON_EXP[k-1];
            return {8'(e[15:8] * 4), e[7:0]};
        end else if (k < 45)
            return {8'((k - 37) * 4), pll[8*(k-38) +: 8]};
        else if (k == 45)
            return {8'd84, 4'b1000, pll[23:20]};
        else if (k < 49)
            return {8'((12 + k - 46) * 4), ld[8*(k-46) +: 8]};
        else
            return {8'd132, 8'h82};
    endfunction

    function automatic string write_tag(input int k);
        if (k == 0) return "R2";
        else if (k < 38) return "R3";
        else if (k < 45) return "R4";
        else if (k == 45) return "R5";
        else return "R6";
    endfunction

    task automatic run_seq(input scen_t s, input bit mid_start);
        int wb, rb, db, bb, ob, waited, nr;
        logic [15:0] ex;
        @(negedge clk);
        stall_mode = s.stall;
        lock_at    = rd_cnt + int'(s.lock_after);
        wb = wr_cnt; rb = rd_cnt; db = done_cnt; bb = rd_bad; ob = ovl_cnt;
        pll_div  = s.pll;
        lock_det = s.ld;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check_eq("R11 outcome cleared by start", {30'd0, lock_ok, timeout}, 0);
        if (mid_start) begin
            repeat (10) @(negedge clk);
            pll_div  = ~s.pll;
            lock_det = ~s.ld;
            start    = 1'b1;   // R12: must be ignored
            @(negedge clk);
            start = 1'b0;
        end
        waited = 0;
        while (done_cnt == db && waited < 5000) begin
            @(negedge clk);
            waited++;
        end
        repeat (20) @(negedge clk);
        check_eq(mid_start ? "R12 single done" : "R11 single done", done_cnt - db, 1);
        check_eq(mid_start ? "R12 write count" : "R6 write count", wr_cnt - wb, 50);
        for (int k = 0; k < 50; k++) begin
            ex = exp_write(k, s.pll, s.ld);
            check_eq({mid_start ? "R12/" : "", write_tag(k), " write"},
                     {log_addr[(wb+k)%LOGN], log_data[(wb+k)%LOGN]}, ex);
        end
        nr = rd_cnt - rb;
        check_eq("R10 poll count", nr, int'(s.exp_reads));
        check_eq("R8 status address", rd_bad - bb, 0);
        check_eq("R7 no read during write", ovl_cnt - ob, 0);
        for (int i = 1; i < nr; i++)
            check_eq("R9 poll spacing", rd_cyc[(rb+i)%LOGN] - rd_cyc[(rb+i-1)%LOGN], POLL_CYC + 2);
        check_eq("R10 lock_ok", int'(lock_ok), int'(s.exp_lock));
        check_eq("R10 timeout", int'(timeout), int'(s.exp_tout));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; pll_div = '0; lock_det = '0;
        stall_mode = 1'b0; lock_at = 1000;
        repeat (3) @(negedge clk);
        check_eq("R1 reset outputs", {27'd0, wvalid, rreq, done, lock_ok, timeout}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_eq("R1 idle outputs", {27'd0, wvalid, rreq, done, lock_ok, timeout}, 0);

        for (int n = 0; n < NSCEN; n++)
            run_seq(SCEN[n], 1'b0);

        // R12: start pulse and input change mid-sequence
        run_seq(SCEN[1], 1'b1);

        // R1: reset in the middle of a sequence
        @(negedge clk);
        stall_mode = 1'b1;
        pll_div = SCEN[0].pll; lock_det = SCEN[0].ld;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_eq("R1 mid-run reset", {27'd0, wvalid, rreq, done, lock_ok, timeout}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check_eq("R1 stays idle after reset", {28'd0, wvalid, rreq, done, lock_ok}, 0);
        run_seq(SCEN[0], 1'b0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule